// File: doc/BRIEF.md
# Self-Test Frame Pattern Source

This block generates a deterministic test stream for a four-lane parallel interface. The stream is organised in repeating frames. Each frame starts with a synchronisation header, twelve bytes of 0xF6 and then twelve bytes of 0x28. The rest of the frame is filled with a seven-stage pseudorandom sequence. A receiver's frame aligner can lock onto the header, and a bit-error checker can follow the payload.

When the active-low test select is low, the block drives every lane with a copy of the stream in place of the external lane data. Each lane's copy is one clock later than the copy on the lane below it, so the four lanes carry decorrelated data. When the test select is high, the external data passes through. The generator is held at the start of a frame, so every entry into test mode starts a frame from the beginning.

Top module: `bist_pattern_src`

## Requirements
- R1: While the reset is asserted, and until the first clock after it is released internally, every bit of `lane_out` is 0.
- R2: When `test_n` is sampled high at a clock edge, `lane_out` takes the value of `ext_data` sampled at that same edge.
- R3: From entry into test mode, lane 0 sends 96 header bits of byte 0xF6 and then 96 bits of byte 0x28, each byte MSB first and one bit per clock.
- R4: After the header, lane 0 carries the output of a seven-stage shift register with taps from x^7 + x^6 + 1. The output is the oldest stage, the feedback is the XOR of stages 7 and 6, and the register is seeded with all ones at frame start after entry.
- R5: The pseudorandom register does not advance during header bits. The payload of each later frame continues the sequence from where the previous frame's payload stopped.
- R6: A frame is FRAME_BYTES bytes long (9720 by default, 77760 bits), and the header recurs at its start every frame.
- R7: In test mode, lane k (k = 1..3) shows the lane 0 stream delayed by k clocks. During the first k clocks after entry, lane k shows 0.
- R8: Leaving test mode and entering it again restarts the pattern at the first header bit, with the pseudorandom register reseeded.
- R9: The pseudorandom register never holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| test_n | input | 1 | Active-low test select; low replaces lane data with the pattern |
| ext_data | input | 4 | External lane bits used in normal operation |
| lane_out | output | 4 | Registered lane bits, one per lane per clock |

## Verification
The hardest case to reach from the ports is the frame boundary. Only there do the header recurrence and the continuation of the pseudorandom sequence across frames become visible, and getting there takes 77760 consecutive clocks in test mode. The stimulus first exits and re-enters test mode to exercise the restart. It then holds test mode for a full frame plus a few hundred bits, while a behavioural model tracks frame position, the sequence state and a short per-lane history. Every clock is compared.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam logic [7:0] SYNC_BYTE_A = 8'hF6;
  localparam logic [7:0] SYNC_BYTE_B = 8'h28;
  typedef enum logic {PH_HDR = 1'b0, PH_PAY = 1'b1} phase_e;
endpackage

// File: rtl/bist_frame_ctr.sv
module bist_frame_ctr #(
  parameter int FRAME_BYTES = 9720,
  parameter int HDR_EACH    = 12,
  localparam int FRAME_BITS = FRAME_BYTES * 8,
  localparam int PW         = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  output logic [PW-1:0]     pos_o,
  output bist_pkg::phase_e  phase_o,
  output logic              hdr_bit_o
);
  localparam int HDR_A_BITS = HDR_EACH * 8;
  localparam int HDR_BITS   = HDR_EACH * 16;

  logic [PW-1:0] pos_q, pos_d;
  logic [7:0]    cur_byte;

  always_comb begin
    pos_d = pos_q;
    if (clear)
      pos_d = '0;
    else if (adv)
      pos_d = (pos_q == PW'(FRAME_BITS - 1)) ? '0 : pos_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  always_comb begin
    cur_byte  = (pos_q < PW'(HDR_A_BITS)) ? bist_pkg::SYNC_BYTE_A : bist_pkg::SYNC_BYTE_B;
    hdr_bit_o = cur_byte[~pos_q[2:0]];
    phase_o   = (pos_q < PW'(HDR_BITS)) ? bist_pkg::PH_HDR : bist_pkg::PH_PAY;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/bist_prbs.sv
module bist_prbs #(
  parameter int W   = 7,
  parameter int TAP = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] state_o,
  output logic         bit_o
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clear)
      st_d = '1;
    else if (step)
      st_d = {st_q[W-2:0], st_q[W-1] ^ st_q[TAP-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '1;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
  assign bit_o   = st_q[W-1];
endmodule

// File: rtl/bist_lane_skew.sv
module bist_lane_skew #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_n,
  input  logic             base,
  input  logic [LANES-1:0] ext,
  output logic [LANES-1:0] lane_q
);
  logic [LANES-1:0] tap;
  logic [LANES-1:0] lane_d;

  assign tap[0] = base;

  for (genvar k = 1; k < LANES; k++) begin : g_dly
    logic dly_q, dly_d;
    always_comb dly_d = test_n ? 1'b0 : tap[k-1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= 1'b0;
      else        dly_q <= dly_d;
    end
    assign tap[k] = dly_q;
  end

  always_comb lane_d = test_n ? ext : tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end
endmodule

// File: rtl/bist_pattern_src.sv
module bist_pattern_src #(
  parameter int LANES       = 4,
  parameter int FRAME_BYTES = 9720,
  parameter int HDR_EACH    = 12,
  parameter int PRBS_W      = 7,
  parameter int PRBS_TAP    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_n,
  input  logic [LANES-1:0] ext_data,
  output logic [LANES-1:0] lane_out
);
  localparam int FRAME_BITS = FRAME_BYTES * 8;
  localparam int PW         = $clog2(FRAME_BITS);

  logic [1:0]        rst_pipe;
  logic              rst_sync;
  logic [PW-1:0]     pos;
  bist_pkg::phase_e  phase;
  logic              hdr_bit;
  logic [PRBS_W-1:0] prbs_state;
  logic              prbs_bit;
  logic              base_bit;
  logic              in_test;
  logic              prbs_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  assign in_test   = ~test_n;
  assign prbs_step = in_test && (phase == bist_pkg::PH_PAY);
  assign base_bit  = (phase == bist_pkg::PH_HDR) ? hdr_bit : prbs_bit;

  bist_frame_ctr #(.FRAME_BYTES(FRAME_BYTES), .HDR_EACH(HDR_EACH)) u_ctr (
    .clk(clk), .rst_n(rst_sync), .clear(test_n), .adv(in_test),
    .pos_o(pos), .phase_o(phase), .hdr_bit_o(hdr_bit)
  );

  bist_prbs #(.W(PRBS_W), .TAP(PRBS_TAP)) u_prbs (
    .clk(clk), .rst_n(rst_sync), .clear(test_n), .step(prbs_step),
    .state_o(prbs_state), .bit_o(prbs_bit)
  );

  bist_lane_skew #(.LANES(LANES)) u_skew (
    .clk(clk), .rst_n(rst_sync), .test_n(test_n), .base(base_bit),
    .ext(ext_data), .lane_q(lane_out)
  );
endmodule

// File: rtl/bist_pattern_chk.sv
module bist_pattern_chk #(
  parameter int LANES  = 4,
  parameter int PW     = 17,
  parameter int PRBS_W = 7,
  parameter int FRAME_BITS = 77760
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_n,
  input logic [LANES-1:0]  ext_data,
  input logic [LANES-1:0]  lane_out,
  input logic [PW-1:0]     pos,
  input bist_pkg::phase_e  phase,
  input logic [PRBS_W-1:0] prbs_state
);
  // R9
  prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_state != '0);

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_n |=> lane_out == $past(ext_data));

  // R5
  prbs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_n && phase == bist_pkg::PH_HDR) |=> $stable(prbs_state));

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= PW'(FRAME_BITS - 1));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_n |=> (pos == '0 && prbs_state == '1));

  for (genvar k = 1; k < LANES; k++) begin : g_skew
    // R7
    lane_skew_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_n && $past(!test_n)) |=> lane_out[k] == $past(lane_out[k-1]));
  end
endmodule

bind bist_pattern_src bist_pattern_chk #(
  .LANES(LANES), .PW(PW), .PRBS_W(PRBS_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_sync), .test_n(test_n), .ext_data(ext_data),
  .lane_out(lane_out), .pos(pos), .phase(phase), .prbs_state(prbs_state)
);

// File: tb/sim_bist_pattern_src.sv
module sim_bist_pattern_src;
  localparam int FRAME_BITS = 9720 * 8;
  localparam int HDR_BITS   = 192;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       test_n;
  logic [3:0] ext_data;
  logic [3:0] lane_out;

  int checks = 0;
  int fails  = 0;

  int fpos;
  int frame_no;
  int ps;
  logic hist[$];
  logic reentered;

  always #2 clk = ~clk;

  bist_pattern_src u0 (
    .clk(clk), .rst_n(rst_n), .test_n(test_n),
    .ext_data(ext_data), .lane_out(lane_out)
  );

  task automatic model_restart();
    fpos = 0;
    ps   = 127;
    hist.delete();
  endtask

  function automatic logic next_base();
    logic b;
    int byt;
    if (fpos < HDR_BITS) begin
      byt = (fpos < 96) ? 'hF6 : 'h28;
      b = logic'((byt >> (7 - (fpos % 8))) & 1);
    end else begin
      b  = logic'((ps >> 6) & 1);
      ps = ((ps << 1) | (((ps >> 6) ^ (ps >> 5)) & 1)) & 127;
    end
    fpos = fpos + 1;
    if (fpos == FRAME_BITS) begin
      fpos = 0;
      frame_no = frame_no + 1;
    end
    return b;
  endfunction

  task automatic cyc(input logic tn, input logic [3:0] ext);
    logic [3:0] exp;
    string tag;
    int p0;
    test_n   = tn;
    ext_data = ext;
    if (tn) begin
      model_restart();
      frame_no = 0;
      exp = ext;
      tag = "R2";
    end else begin
      p0 = fpos;
      if (p0 < HDR_BITS)
        tag = reentered ? "R8" : ((frame_no > 0) ? "R6" : "R3");
      else
        tag = (frame_no > 0) ? "R5" : "R4";
      hist.push_front(next_base());
      if (hist.size() > 4) void'(hist.pop_back());
      for (int k = 0; k < 4; k++)
        exp[k] = (hist.size() > k) ? hist[k] : 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (lane_out !== exp) begin
      fails++;
      if (!tn && lane_out[0] === exp[0]) tag = "R7";
      $display("FAIL %s fpos=%0d actual=%b expected=%b", tag, fpos, lane_out, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; test_n = 1'b1; ext_data = 4'hF;
    frame_no = 0; reentered = 1'b0;
    model_restart();
    repeat (3) @(negedge clk);
    // R1: output held at zero in reset despite external ones
    checks++;
    if (lane_out !== 4'h0) begin
      fails++;
      $display("FAIL R1 actual=%b expected=0000", lane_out);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2: bypass with varied lane data
    for (int i = 0; i < 20; i++) cyc(1'b1, 4'((i * 7) ^ (i >> 1)));
    // R3, R4, R7: first entry, header then payload start
    for (int i = 0; i < 400; i++) cyc(1'b0, 4'h0);
    // R8: leave and re-enter mid-payload
    for (int i = 0; i < 5; i++) cyc(1'b1, 4'hA);
    reentered = 1'b1;
    for (int i = 0; i < HDR_BITS; i++) cyc(1'b0, 4'h5);
    reentered = 1'b0;
    // R5, R6, R9: run past one whole frame, header recurs and sequence continues
    for (int i = 0; i < FRAME_BITS + 400; i++) cyc(1'b0, 4'h3);
    for (int i = 0; i < 4; i++) cyc(1'b1, 4'(i + 9));
    summary();
  end
endmodule